// File: doc/BRIEF.md
# Speed-Gated Direction Reversal Guard

This block sits between a motor's direction command and the commutation logic of a three-phase brushless drive. It accepts a direction request that may arrive asynchronously, a speed-high flag from an external comparator, and a single-cycle tick from the PWM oscillator. From these it produces the direction that the commutation decoder should use. It also produces an inhibit flag that forces every power driver off while a reversal is in flight.

A new direction is accepted only while the motor is slow. A holding stage takes the request only while the speed-high flag is low and keeps its value otherwise. The accepted value then shifts through a two-stage register that advances only on PWM ticks. A reversal therefore reaches the commutation logic no sooner than one PWM period after it is accepted, and no later than two. The drivers stay blanked whenever the request disagrees with the held value, or whenever any stage of the tick-clocked register disagrees with its neighbour. Each toggle of the request also raises a one-cycle tachometer pulse request, at any speed.

Both asynchronous inputs pass through a two-flop synchroniser. Reset is synchronous and seeds the holding stage and the tick-clocked stages from the synchronised request. The block therefore leaves reset with no pending reversal and no spurious blanking.

Top module: `dir_reversal_guard`

## Requirements
- R1: While the synchronised speed-high flag is low, a change of the direction request is taken by the holding stage on the third clock edge after the input changes (two synchroniser flops plus the hold register).
- R2: While the synchronised speed-high flag is high, the holding stage keeps its value, so `eff_dir_o` does not follow request toggles however many PWM ticks occur. When the flag falls, the pending request is accepted.
- R3: The tick-clocked register advances only on clock edges where `pwm_tick_i` is 1. An accepted change reaches `eff_dir_o` on the second tick after acceptance, never on the first and never between ticks.
- R4: `drive_inhibit_o` is 1 whenever the synchronised request differs from the holding stage. This includes the whole time a toggle is held back at high speed. The flag clears when the request returns to the held value.
- R5: `drive_inhibit_o` is 1 whenever the holding stage differs from the first register stage, or the first stage differs from the second. It returns to 0 only when all of them agree.
- R6: Each toggle of the direction request gives exactly one 1-cycle high pulse on `tach_pulse_o`, whatever the speed flag. The pulse appears after the second clock edge following the input change.
- R7: After reset with a stable request, `eff_dir_o` equals the request, and `drive_inhibit_o` and `tach_pulse_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Synchronous active-low reset; seeds state from the synchronised request |
| dir_req_i | input | 1 | Asynchronous direction request (1 = forward, 0 = reverse) |
| speed_high_i | input | 1 | Asynchronous flag, 1 when motor speed is above the reversal limit |
| pwm_tick_i | input | 1 | One-cycle pulse per PWM oscillator period, synchronous to clk_i |
| eff_dir_o | output | 1 | Direction used by the commutation decoder |
| drive_inhibit_o | output | 1 | 1 forces all high-side and low-side drivers off |
| tach_pulse_o | output | 1 | One-cycle request for a tachometer pulse on each request toggle |

## Verification
The hardest state to reach is a request that is undone while the reversal is half-way through the tick-clocked register. In that state the holding stage has already returned to the old direction, and the two register stages hold opposite values. The stimulus builds it from the ports. It reverses at low speed, lets exactly one tick pass, and restores the original request before the second tick. The bench then checks that `eff_dir_o` shows the brief opposite value the shift produces, and that blanking stays on until a further tick brings every stage back into agreement.

// File: rtl/revguard_pkg.sv
package revguard_pkg;

    localparam int unsigned SYNC_DEPTH_DEF = 2;
    localparam int unsigned PIPE_DEPTH_DEF = 2;

    typedef struct packed {
        logic held;
    } gate_state_t;

    typedef struct packed {
        logic prev;
    } edge_state_t;

endpackage

// File: rtl/rg_sync.sv
module rg_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_d [STAGES];
    logic [WIDTH-1:0] chain_q [STAGES];

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < int'(STAGES); i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk_i) begin
        for (int i = 0; i < int'(STAGES); i++) begin
            chain_q[i] <= chain_d[i];
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/rg_dir_gate.sv
module rg_dir_gate
    import revguard_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic dir_i,
    input  logic fast_i,
    output logic held_o,
    output logic differ_o
);
    gate_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!fast_i) begin
            st_d.held = dir_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.held <= dir_i;
        end else begin
            st_q <= st_d;
        end
    end

    assign held_o   = st_q.held;
    assign differ_o = dir_i ^ st_q.held;

    // R2
    hold_when_fast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fast_i |=> $stable(held_o));

    // R1
    follow_when_slow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fast_i |=> (held_o == $past(dir_i)));
endmodule

// File: rtl/rg_dir_pipe.sv
module rg_dir_pipe #(
    parameter int unsigned DEPTH = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic seed_i,
    input  logic din_i,
    output logic dout_o,
    output logic mismatch_o
);
    logic [DEPTH-1:0] stg_d, stg_q;
    logic [DEPTH-1:0] diff;

    always_comb begin
        stg_d = stg_q;
        if (tick_i) begin
            stg_d[0] = din_i;
            for (int i = 1; i < int'(DEPTH); i++) begin
                stg_d[i] = stg_q[i-1];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            stg_q <= {DEPTH{seed_i}};
        end else begin
            stg_q <= stg_d;
        end
    end

    generate
        for (genvar g = 0; g < int'(DEPTH); g++) begin : g_diff
            if (g == 0) begin : g_head
                assign diff[g] = din_i ^ stg_q[0];
            end else begin : g_link
                assign diff[g] = stg_q[g] ^ stg_q[g-1];
            end
        end
    endgenerate

    assign dout_o     = stg_q[DEPTH-1];
    assign mismatch_o = |diff;

    // R3
    no_shift_without_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(dout_o));

    // R5
    agree_stays_put_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!mismatch_o && tick_i && $stable(din_i)) |=> !mismatch_o);
endmodule

// File: rtl/dir_reversal_guard.sv
module dir_reversal_guard
    import revguard_pkg::*;
#(
    parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF,
    parameter int unsigned PIPE_DEPTH = PIPE_DEPTH_DEF
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic dir_req_i,
    input  logic speed_high_i,
    input  logic pwm_tick_i,
    output logic eff_dir_o,
    output logic drive_inhibit_o,
    output logic tach_pulse_o
);
    localparam int unsigned SYNC_W = 2;

    logic [SYNC_W-1:0] raw_in, synced;
    logic dir_s, fast_s;
    logic held, gate_differ, pipe_mismatch;
    edge_state_t edg_d, edg_q;

    assign raw_in = {speed_high_i, dir_req_i};

    rg_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_DEPTH)) u_sync (
        .clk_i   (clk_i),
        .async_i (raw_in),
        .sync_o  (synced)
    );

    assign dir_s  = synced[0];
    assign fast_s = synced[1];

    rg_dir_gate u_gate (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .dir_i    (dir_s),
        .fast_i   (fast_s),
        .held_o   (held),
        .differ_o (gate_differ)
    );

    rg_dir_pipe #(.DEPTH(PIPE_DEPTH)) u_pipe (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (pwm_tick_i),
        .seed_i     (dir_s),
        .din_i      (held),
        .dout_o     (eff_dir_o),
        .mismatch_o (pipe_mismatch)
    );

    always_comb begin
        edg_d      = edg_q;
        edg_d.prev = dir_s;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            edg_q.prev <= dir_s;
        end else begin
            edg_q <= edg_d;
        end
    end

    assign tach_pulse_o    = dir_s ^ edg_q.prev;
    assign drive_inhibit_o = gate_differ | pipe_mismatch;

    // R6
    tach_on_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(dir_s) |-> tach_pulse_o);

    // R5
    eff_change_blanked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(eff_dir_o) |-> $past(drive_inhibit_o));

    // R4
    fast_pending_blanked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fast_s && (dir_s != held)) |-> drive_inhibit_o);

    // R7
    clean_start_chk: assert property (@(posedge clk_i)
        ($rose(rst_ni) && $stable(dir_s)) |-> (!drive_inhibit_o && !tach_pulse_o));
endmodule

// File: tb/dir_reversal_guard_tb.sv
module dir_reversal_guard_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dir_req = 1'b1;
    logic speed_high = 1'b0;
    logic tick = 1'b0;
    logic eff_dir, inhibit, tach;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    dir_reversal_guard u_dut (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .dir_req_i       (dir_req),
        .speed_high_i    (speed_high),
        .pwm_tick_i      (tick),
        .eff_dir_o       (eff_dir),
        .drive_inhibit_o (inhibit),
        .tach_pulse_o    (tach)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        step(1);
        tick = 1'b0;
    endtask

    task automatic t_reset();
        dir_req = 1'b1; speed_high = 1'b0; rst_n = 1'b0;
        step(6);
        rst_n = 1'b1;
        step(1);
        chk("R7", "eff_dir", eff_dir, 1'b1);
        chk("R7", "inhibit", inhibit, 1'b0);
        chk("R7", "tach", tach, 1'b0);
    endtask

    task automatic t_slow_reverse();
        dir_req = 1'b0;
        step(1);
        chk("R6", "tach early", tach, 1'b0);
        step(1);
        chk("R6", "tach pulse", tach, 1'b1);
        chk("R4", "inhibit on request", inhibit, 1'b1);
        step(1);
        chk("R6", "tach one cycle", tach, 1'b0);
        step(10);
        chk("R3", "eff held without tick", eff_dir, 1'b1);
        chk("R5", "inhibit pending", inhibit, 1'b1);
        pulse_tick();
        chk("R3", "eff after first tick", eff_dir, 1'b1);
        chk("R5", "inhibit mid pipe", inhibit, 1'b1);
        step(5);
        chk("R3", "eff between ticks", eff_dir, 1'b1);
        pulse_tick();
        chk("R1", "eff after second tick", eff_dir, 1'b0);
        chk("R5", "inhibit released", inhibit, 1'b0);
    endtask

    task automatic t_fast_hold_and_undo();
        speed_high = 1'b1;
        step(3);
        dir_req = 1'b1;
        step(2);
        chk("R6", "tach at speed", tach, 1'b1);
        step(1);
        for (int k = 0; k < 4; k++) begin
            pulse_tick();
            step(2);
        end
        chk("R2", "eff held at speed", eff_dir, 1'b0);
        chk("R4", "inhibit while held", inhibit, 1'b1);
        dir_req = 1'b0;
        step(2);
        chk("R6", "tach on undo", tach, 1'b1);
        chk("R4", "inhibit cleared on undo", inhibit, 1'b0);
        step(1);
        chk("R6", "tach undo one cycle", tach, 1'b0);
        speed_high = 1'b0;
        step(3);
        pulse_tick(); pulse_tick();
        chk("R2", "eff after slow down no change", eff_dir, 1'b0);
    endtask

    task automatic t_fast_release();
        speed_high = 1'b1;
        step(3);
        dir_req = 1'b1;
        step(3);
        pulse_tick(); pulse_tick(); pulse_tick();
        chk("R2", "eff blocked", eff_dir, 1'b0);
        speed_high = 1'b0;
        step(3);
        chk("R4", "inhibit after accept", inhibit, 1'b1);
        pulse_tick();
        chk("R3", "eff one tick after accept", eff_dir, 1'b0);
        pulse_tick();
        chk("R2", "eff after release", eff_dir, 1'b1);
        chk("R5", "inhibit after release", inhibit, 1'b0);
    endtask

    task automatic t_midpipe_undo();
        dir_req = 1'b0;
        step(3);
        pulse_tick();
        chk("R3", "eff first stage only", eff_dir, 1'b1);
        dir_req = 1'b1;
        step(3);
        chk("R5", "inhibit stages split", inhibit, 1'b1);
        pulse_tick();
        chk("R3", "eff shows shifted value", eff_dir, 1'b0);
        chk("R5", "inhibit still split", inhibit, 1'b1);
        pulse_tick();
        chk("R3", "eff restored", eff_dir, 1'b1);
        chk("R5", "inhibit all agree", inhibit, 1'b0);
    endtask

    initial begin
        t_reset();
        t_slow_reverse();
        t_fast_hold_and_undo();
        t_fast_release();
        t_midpipe_undo();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule